// File: doc/BRIEF.md
# Low-Speed USB Serial Receiver

This block turns the two single-ended levels of a low-speed USB cable (1.5 Mbit/s) into a stream of bytes. It runs from a clock that is OVS times the bit rate, by default 12 MHz for eight samples per bit. Both line inputs pass through a synchroniser first.

The block waits for a falling edge of D- into the K state and then watches the sync field until it has sampled K twice in a row. After that it decodes NRZI, removes stuffed bits and packs the data bits into bytes, least significant bit first. Each byte leaves on `rx_byte` with a one-cycle `rx_valid` strobe.

The sample point is moved back to the middle of the bit on every D- transition, so a small difference between the sender's bit rate and the local clock does no harm. Reception ends in one of three ways: an SE0 gives `rx_eop`, a run of seven ones gives `rx_error`, and a byte beyond the limit gives `rx_overflow`. The block then returns to waiting for the next packet.

Top module: `usbls_rx`

## Requirements
- R1: After reset every output is 0 and the block waits for a new packet.
- R2: A J-to-K falling edge on D- (with D+ high) starts the sync search. `rx_active` rises only after two consecutive bit samples read K. A sync field that only alternates J and K never raises `rx_active`, and an SE0 during the search abandons it.
- R3: NRZI decoding gives 1 when the sampled D- level equals the previous sample and 0 when it differs. The final K of the sync field is the first reference level.
- R4: The last sync bit counts as a decoded 1. When six consecutive decoded 1s have been seen, the next bit is a stuffed 0. It is dropped and never reaches a byte.
- R5: If the bit after six consecutive 1s is itself a 1, the block gives a one-cycle `rx_error`. `rx_active` drops in that same cycle and no `rx_eop` follows.
- R6: An SE0 is a sample in which D- and D+ are both low; D- low with D+ high is a K. An SE0 sample during reception gives a one-cycle `rx_eop`. If 1 to 7 data bits of an unfinished byte are held, they appear on `rx_byte` in that same cycle with `rx_valid`. The bits sit in the low positions of the byte and the upper bits are 0.
- R7: The first data bit received becomes bit 0 of `rx_byte`. Each completed byte gives exactly one one-cycle `rx_valid` pulse.
- R8: At most MAX_BYTES bytes (default 8) are delivered per packet, counting a partial byte at SE0. Any further byte, full or partial, gives a one-cycle `rx_overflow` instead of `rx_valid`. Reception then ends with no `rx_eop`.
- R9: Every D- transition restarts the phase count, and each bit is sampled OVS/2 clocks after the transition was seen. Packets whose bit period differs from nominal by ±1% are received without error.
- R10: Each packet ends with at most one of `rx_eop`, `rx_error` or `rx_overflow`. `rx_active` is low in the cycle that pulse is shown, and the next packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | D+ line level, asynchronous |
| dm_in | input | 1 | D- line level, asynchronous |
| rx_byte | output | 8 | Received byte, least significant bit first on the wire |
| rx_valid | output | 1 | One-cycle strobe: rx_byte holds a new byte |
| rx_active | output | 1 | High from sync lock until the packet ends |
| rx_eop | output | 1 | One-cycle pulse: packet ended by SE0 |
| rx_overflow | output | 1 | One-cycle pulse: byte limit exceeded, packet aborted |
| rx_error | output | 1 | One-cycle pulse: seven ones in a row, packet aborted |

## Verification
The stuffing-run counter and the NRZI reference level carry over from one bit to the next. If either is wrong, the damage shows on the ports within a byte: the affected byte is wrong, a stuffed bit stays in the data, or `rx_error` fires. A drifting phase count shows up only on long runs without transitions. For that reason the bench runs packets full of 0xFF bytes at bit periods 1% off nominal. A wrong byte count shows up as a missing or extra `rx_overflow` at the limit, which the bench checks both with a full final byte and with a partial one.

// File: rtl/usbls_rx_pkg.sv
`timescale 1ns/1ps
package usbls_rx_pkg;
   localparam int BYTE_W    = 8;
   localparam int IDX_W     = 3;
   localparam int RUN_W     = 3;
   localparam int STUFF_RUN = 6;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_SYNC = 2'd1,
      ST_DATA = 2'd2
   } rx_state_e;
endpackage

// File: rtl/usbls_rx_sync.sv
`timescale 1ns/1ps
module usbls_rx_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("usbls_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_async;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/usbls_rx_phase.sv
`timescale 1ns/1ps
module usbls_rx_phase #(
   parameter int OVS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dm_s,
   input  logic dp_s,
   output logic strobe,
   output logic k_edge
);
   localparam int          CW   = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [CW-1:0] ONE  = CW'(1);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("usbls_rx_phase: OVS must be even and at least 4");
      end
   endgenerate

   logic          dm_d;
   logic [CW-1:0] ph;
   logic          dm_chg;

   assign dm_chg = dm_s ^ dm_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dm_d <= 1'b1;
         ph   <= '0;
      end else begin
         dm_d <= dm_s;
         if (dm_chg)          ph <= ONE;
         else if (ph == LAST) ph <= '0;
         else                 ph <= ph + ONE;
      end
   end

   assign strobe = (ph == MID);
   assign k_edge = dm_d & ~dm_s & dp_s;

   // R9: samples are one bit apart, never in adjacent cycles
   a_r9_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/usbls_rx_core.sv
`timescale 1ns/1ps
module usbls_rx_core
   import usbls_rx_pkg::*;
#(
   parameter int MAX_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dm_s,
   input  logic              dp_s,
   input  logic              strobe,
   input  logic              k_edge,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_eop,
   output logic              rx_overflow,
   output logic              rx_error
);
   localparam int            CNT_W    = $clog2(MAX_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(STUFF_RUN);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

   generate
      if (MAX_BYTES < 1) begin : g_bad_max
         $error("usbls_rx_core: MAX_BYTES must be at least 1");
      end
   endgenerate

   rx_state_e         state;
   logic              prev_lvl;
   logic [RUN_W-1:0]  ones;
   logic [IDX_W-1:0]  bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  byte_cnt;

   logic              dbit;
   logic              se0;
   logic              full;
   logic [BYTE_W-1:0] merged;

   always_comb begin
      dbit   = (dm_s == prev_lvl);
      se0    = !dm_s && !dp_s;
      full   = (byte_cnt == CNT_MAX);
      merged = shreg | (BYTE_W'(dbit) << bit_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_HUNT;
         prev_lvl    <= 1'b1;
         ones        <= '0;
         bit_idx     <= '0;
         shreg       <= '0;
         byte_cnt    <= '0;
         rx_byte     <= '0;
         rx_valid    <= 1'b0;
         rx_eop      <= 1'b0;
         rx_overflow <= 1'b0;
         rx_error    <= 1'b0;
      end else begin
         rx_valid    <= 1'b0;
         rx_eop      <= 1'b0;
         rx_overflow <= 1'b0;
         rx_error    <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (k_edge) begin
                  state    <= ST_SYNC;
                  prev_lvl <= 1'b1;
               end
            end
            ST_SYNC: begin
               if (strobe) begin
                  if (se0) begin
                     state <= ST_HUNT;
                  end else begin
                     if (!dm_s && !prev_lvl) begin
                        state    <= ST_DATA;
                        ones     <= RUN_W'(1);
                        bit_idx  <= '0;
                        shreg    <= '0;
                        byte_cnt <= '0;
                     end
                     prev_lvl <= dm_s;
                  end
               end
            end
            ST_DATA: begin
               if (strobe) begin
                  if (se0) begin
                     state <= ST_HUNT;
                     if (bit_idx != '0) begin
                        if (full) begin
                           rx_overflow <= 1'b1;
                        end else begin
                           rx_byte  <= shreg;
                           rx_valid <= 1'b1;
                           rx_eop   <= 1'b1;
                        end
                     end else begin
                        rx_eop <= 1'b1;
                     end
                  end else begin
                     prev_lvl <= dm_s;
                     if (ones == RUN_LIM) begin
                        if (dbit) begin
                           rx_error <= 1'b1;
                           state    <= ST_HUNT;
                        end else begin
                           ones <= '0;
                        end
                     end else begin
                        ones <= dbit ? ones + RUN_W'(1) : '0;
                        if (bit_idx == IDX_TOP) begin
                           bit_idx <= '0;
                           shreg   <= '0;
                           if (full) begin
                              rx_overflow <= 1'b1;
                              state       <= ST_HUNT;
                           end else begin
                              rx_byte  <= merged;
                              rx_valid <= 1'b1;
                              byte_cnt <= byte_cnt + CNT_W'(1);
                           end
                        end else begin
                           shreg   <= merged;
                           bit_idx <= bit_idx + IDX_W'(1);
                        end
                     end
                  end
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   assign rx_active = (state == ST_DATA);

   // R2: reception never starts straight from the edge search
   a_r2_no_skip_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT) |=> (state != ST_DATA));
   // R4: the ones run never exceeds the stuffing limit
   a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= RUN_LIM);
   // R5: an error pulse follows a full run of ones
   a_r5_error_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |-> ($past(ones) == RUN_LIM));
   // R7: byte strobes are never back to back
   a_r7_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R8: the stored byte count stays within the limit
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= CNT_MAX);
   // R8: an overflowing byte is never delivered
   a_r8_ovf_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |-> !rx_valid);
   // R10: only one kind of packet end at a time
   a_r10_one_end: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_eop, rx_error, rx_overflow}));
   // R10: a packet end closes an active reception
   a_r10_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eop || rx_error || rx_overflow) |-> (!rx_active && $past(rx_active)));
endmodule

// File: rtl/usbls_rx.sv
`timescale 1ns/1ps
module usbls_rx
   import usbls_rx_pkg::*;
#(
   parameter int OVS         = 8,
   parameter int MAX_BYTES   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dp_in,
   input  logic              dm_in,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_eop,
   output logic              rx_overflow,
   output logic              rx_error
);
   logic [1:0] line_s;
   logic       strobe;
   logic       k_edge;

   usbls_rx_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({dp_in, dm_in}),
      .d_sync  (line_s)
   );

   usbls_rx_phase #(
      .OVS (OVS)
   ) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .dm_s   (line_s[0]),
      .dp_s   (line_s[1]),
      .strobe (strobe),
      .k_edge (k_edge)
   );

   usbls_rx_core #(
      .MAX_BYTES (MAX_BYTES)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .dm_s        (line_s[0]),
      .dp_s        (line_s[1]),
      .strobe      (strobe),
      .k_edge      (k_edge),
      .rx_byte     (rx_byte),
      .rx_valid    (rx_valid),
      .rx_active   (rx_active),
      .rx_eop      (rx_eop),
      .rx_overflow (rx_overflow),
      .rx_error    (rx_error)
   );
endmodule

// File: tb/usbls_rx_tb.sv
`timescale 1ns/1ps
module usbls_rx_tb;
   localparam int OVS  = 8;
   localparam int MAXB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dp = 1'b0;
   logic       dm = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_valid, rx_active, rx_eop, rx_overflow, rx_error;

   always #5 clk = ~clk;

   usbls_rx #(.OVS(OVS), .MAX_BYTES(MAXB), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_active(rx_active),
      .rx_eop(rx_eop), .rx_overflow(rx_overflow), .rx_error(rx_error));

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   real  bit_ns = 80.0;

   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];
   bit         data_q[$];
   int         n_eop, n_err, n_ovf, n_rise;
   logic       act_d = 1'b0;

   always @(negedge clk) begin
      if (rx_valid) got_q.push_back(rx_byte);
      if (rx_eop) n_eop++;
      if (rx_error) n_err++;
      if (rx_overflow) n_ovf++;
      if (rx_active && !act_d) n_rise++;
      act_d = rx_active;
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_obs();
      got_q.delete();
      n_eop = 0; n_err = 0; n_ovf = 0; n_rise = 0;
   endtask

   task automatic line(input logic p, input logic m);
      dp = p; dm = m;
      #(bit_ns);
   endtask

   task automatic drive_lvl(input logic lvl_dm);
      line(~lvl_dm, lvl_dm);
   endtask

   task automatic add_byte(input logic [7:0] b);
      for (int k = 0; k < 8; k++) data_q.push_back(b[k]);
   endtask

   // Encoder: sync, NRZI data, optional stuffing, SE0, idle
   task automatic send(input bit stuff_en);
      logic lvl;
      int   run;
      for (int i = 0; i < 3; i++) drive_lvl(1'b1);
      for (int i = 0; i < 6; i++) drive_lvl(i[0]);
      drive_lvl(1'b0);
      drive_lvl(1'b0);
      lvl = 1'b0;
      run = 1;
      foreach (data_q[i]) begin
         if (data_q[i]) run++;
         else begin lvl = ~lvl; run = 0; end
         drive_lvl(lvl);
         if (stuff_en && run == 6) begin
            lvl = ~lvl; run = 0;
            drive_lvl(lvl);
         end
      end
      line(1'b0, 1'b0);
      line(1'b0, 1'b0);
      for (int i = 0; i < 3; i++) drive_lvl(1'b1);
      repeat (16) @(posedge clk);
   endtask

   task automatic expect_pkt(input string req);
      int   nfull, rem, nexp;
      bit   ovf;
      logic [7:0] b;
      exp_q.delete();
      nfull = data_q.size() / 8;
      rem   = data_q.size() % 8;
      for (int i = 0; i < nfull; i++) begin
         for (int k = 0; k < 8; k++) b[k] = data_q[8*i+k];
         exp_q.push_back(b);
      end
      if (rem != 0) begin
         b = '0;
         for (int k = 0; k < rem; k++) b[k] = data_q[8*nfull+k];
         exp_q.push_back(b);
      end
      ovf  = exp_q.size() > MAXB;
      nexp = ovf ? MAXB : exp_q.size();
      chk(got_q.size() == nexp, req, "byte count", got_q.size(), nexp);
      for (int i = 0; i < nexp && i < got_q.size(); i++)
         chk(got_q[i] === exp_q[i], req, "byte value", got_q[i], exp_q[i]);
      chk(n_eop == (ovf ? 0 : 1), req, "eop pulses", n_eop, ovf ? 0 : 1);
      chk(n_ovf == (ovf ? 1 : 0), req, "overflow pulses", n_ovf, ovf ? 1 : 0);
      chk(n_err == 0, req, "error pulses", n_err, 0);
      chk(n_rise == 1, req, "active rises", n_rise, 1);
   endtask

   task automatic run_pkt(input string req);
      clear_obs();
      send(1'b1);
      expect_pkt(req);
      data_q.delete();
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      #3 rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1: reset state
      chk({rx_valid, rx_active, rx_eop, rx_overflow, rx_error} == 5'b0, "R1",
          "outputs after reset", {rx_valid, rx_active, rx_eop, rx_overflow, rx_error}, 0);
      chk(rx_byte == 8'h00, "R1", "rx_byte after reset", rx_byte, 0);

      // R3 R7: single byte, LSb first
      add_byte(8'hA5); run_pkt("R3_R7");
      add_byte(8'h01); add_byte(8'h80); run_pkt("R7");

      // R4: heavy stuffing across byte boundaries
      add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h7E); run_pkt("R4");
      add_byte(8'h3F); run_pkt("R4");

      // R6: partial byte at SE0
      add_byte(8'h5A);
      data_q.push_back(1'b1); data_q.push_back(1'b0); data_q.push_back(1'b1);
      data_q.push_back(1'b1); data_q.push_back(1'b0);
      run_pkt("R6");

      // R8: exactly at the limit, one byte over, partial over
      for (int i = 0; i < MAXB; i++) add_byte(8'(8'h10 + i));
      run_pkt("R8");
      for (int i = 0; i < MAXB + 1; i++) add_byte(8'(8'hC3 ^ i));
      run_pkt("R8");
      for (int i = 0; i < MAXB; i++) add_byte(8'(8'h21 * i));
      data_q.push_back(1'b1); data_q.push_back(1'b1); data_q.push_back(1'b0);
      run_pkt("R8");
      add_byte(8'h66); run_pkt("R10");

      // R5: seven ones without stuffing
      clear_obs();
      data_q.push_back(1'b0);
      for (int i = 0; i < 7; i++) data_q.push_back(1'b1);
      send(1'b0);
      data_q.delete();
      chk(n_err == 1, "R5", "error pulses", n_err, 1);
      chk(n_eop == 0, "R5", "eop pulses", n_eop, 0);
      chk(got_q.size() == 0, "R5", "bytes", got_q.size(), 0);
      add_byte(8'h99); run_pkt("R10");

      // R2: alternating sync without double K, then SE0
      clear_obs();
      for (int i = 0; i < 3; i++) drive_lvl(1'b1);
      for (int i = 0; i < 8; i++) drive_lvl(i[0]);
      for (int i = 0; i < 4; i++) drive_lvl(1'b1);
      line(1'b0, 1'b0); line(1'b0, 1'b0);
      for (int i = 0; i < 3; i++) drive_lvl(1'b1);
      repeat (16) @(posedge clk);
      chk(n_rise == 0, "R2", "active rises", n_rise, 0);
      chk(got_q.size() + n_eop + n_err + n_ovf == 0, "R2", "events",
          got_q.size() + n_eop + n_err + n_ovf, 0);
      add_byte(8'hE7); run_pkt("R2");

      // R9: bit period off by one percent, long runs
      bit_ns = 80.8;
      for (int i = 0; i < 6; i++) add_byte(8'hFF);
      run_pkt("R9");
      bit_ns = 79.2;
      for (int i = 0; i < 6; i++) add_byte(8'hFF);
      run_pkt("R9");
      add_byte(8'h00); add_byte(8'hFE); add_byte(8'h7F); run_pkt("R9");

      // Random packets
      for (int p = 0; p < 24; p++) begin
         int nb, rem, sel;
         sel = $urandom % 3;
         bit_ns = (sel == 0) ? 79.2 : ((sel == 1) ? 80.0 : 80.8);
         nb  = 1 + ($urandom % MAXB);
         rem = (($urandom % 4) == 0) ? ($urandom % 8) : 0;
         for (int i = 0; i < nb; i++)
            add_byte((($urandom % 4) == 0) ? 8'hFF : 8'($urandom));
         for (int i = 0; i < rem; i++) data_q.push_back(1'($urandom));
         run_pkt("R3_R4_R7_R9");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule